// File: doc/BRIEF.md
# Alternate-Line Chroma Interpolator

This block rebuilds both color difference components for every video line from a stream in which each line carries only one of them: U on even lines, V on odd lines. Samples enter one per accepted cycle, with a flag that marks the first sample of each line. The block keeps a ring of three line buffers. While line n+1 arrives, it emits line n. The component that line n carries is passed through unchanged. The missing component is the rounded mean of the co-sited samples on lines n-1 and n+1.

The line length is a fixed parameter. The output runs exactly one line behind the input, plus one register stage. Nothing is emitted until the line after the first interpolable line has started.

Top module: `chroma_line_interp`

## Requirements
- R1: After reset, out_valid is 0 and out_u and out_v are 0.
- R2: For an even output line n, out_u equals the sample of line n at the same position.
- R3: For an even output line n, out_v equals the rounded mean of the samples of lines n-1 and n+1 at the same position.
- R4: For an odd output line n, out_v equals the sample of line n at the same position.
- R5: For an odd output line n, out_u equals the rounded mean of the samples of lines n-1 and n+1 at the same position.
- R6: The mean of a and b is (a+b+1)>>1, formed with one extra bit so it never wraps. For example, 255 and 254 give 255, and 0 and 1 give 1.
- R7: The output for position k of line n appears one clock after sample k of line n+1 is accepted. Line 0 is never output.
- R8: out_valid is high only in the cycle after an accepted in-range sample of the third or a later line. While out_valid is low, out_u and out_v hold their values.
- R9: Samples beyond LINE_LEN in a line produce no output and are not stored.
- R10: Samples accepted before the first line-start flag after reset are ignored.
- R11: The first line after reset is line 0, which is even. Parity toggles on each accepted line-start flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is present this cycle |
| in_sol | input | 1 | Input sample is the first of a line (used with in_valid) |
| in_data | input | SAMPLE_W | Color difference sample |
| out_valid | output | 1 | Output pair is valid |
| out_u | output | SAMPLE_W | U component of the output line |
| out_v | output | SAMPLE_W | V component of the output line |

## Verification
The embedded properties check four things on every cycle:
- the sample counter never runs past the line length;
- a line start restarts the position and flips parity;
- the rounded mean always lies between its two inputs;
- out_valid never rises without an accepted sample, and the outputs hold while it is low.

Only the bench scenarios can show the rest. These are the correct selection between passthrough and mean by line parity, the one-line latency, the three-line fill, and the restart of parity after a second reset. The same holds for rejection of over-long and pre-start samples. The bench compares every output against a model of the line history.

// File: rtl/chroma_interp_pkg.sv
`timescale 1ns/1ps
package chroma_interp_pkg;

    // Number of line buffers in the ring: previous, current, incoming.
    localparam int NUM_BANKS = 3;

    typedef logic [1:0] bank_t;

    function automatic bank_t bank_inc(input bank_t b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

    function automatic bank_t bank_dec(input bank_t b);
        return (b == 2'd0) ? 2'd2 : b - 2'd1;
    endfunction

endpackage

// File: rtl/line_tracker.sv
`timescale 1ns/1ps
module line_tracker
    import chroma_interp_pkg::*;
#(
    parameter int LINE_LEN = 64,
    localparam int IDX_W   = $clog2(LINE_LEN + 1),
    localparam int ADDR_W  = $clog2(LINE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sol,
    output bank_t             wr_bank,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic              line_odd,
    output logic              fill_done
);

    localparam logic [IDX_W-1:0] LEN_V = IDX_W'(LINE_LEN);

    typedef struct packed {
        logic             started;
        logic             odd;
        bank_t            bank;
        logic [IDX_W-1:0] cnt;
        logic [1:0]       lines;
    } trk_t;

    trk_t st_d, st_q;

    logic             eff_started;
    logic             eff_odd;
    bank_t            eff_bank;
    logic [IDX_W-1:0] eff_idx;
    logic [1:0]       eff_lines;

    always_comb begin
        st_d        = st_q;
        eff_started = st_q.started;
        eff_odd     = st_q.odd;
        eff_bank    = st_q.bank;
        eff_idx     = st_q.cnt;
        eff_lines   = st_q.lines;

        if (in_valid && in_sol) begin
            eff_started = 1'b1;
            eff_odd     = st_q.started ? ~st_q.odd : 1'b0;
            eff_bank    = bank_inc(st_q.bank);
            eff_idx     = '0;
            eff_lines   = (st_q.lines == 2'd3) ? 2'd3 : st_q.lines + 2'd1;
        end

        if (in_valid) begin
            st_d.started = eff_started;
            st_d.odd     = eff_odd;
            st_d.bank    = eff_bank;
            st_d.lines   = eff_lines;
            st_d.cnt     = (eff_idx == LEN_V) ? eff_idx : eff_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.started <= 1'b0;
            st_q.odd     <= 1'b0;
            st_q.bank    <= 2'd2;
            st_q.cnt     <= '0;
            st_q.lines   <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_bank   = eff_bank;
    assign addr      = eff_idx[ADDR_W-1:0];
    assign in_range  = in_valid && eff_started && (eff_idx < LEN_V);
    assign line_odd  = eff_odd;
    assign fill_done = (eff_lines == 2'd3);

    // R9: position counter saturates at the line length
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LEN_V);

    // R11: a line start restarts the position
    assert_sol_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> (st_q.cnt == IDX_W'(1)));

    // R11: parity flips on every line start after the first
    assert_parity_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol && st_q.started) |=> (st_q.odd != $past(st_q.odd)));

endmodule

// File: rtl/line_store.sv
`timescale 1ns/1ps
module line_store
    import chroma_interp_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int LINE_LEN = 64,
    localparam int ADDR_W  = $clog2(LINE_LEN)
) (
    input  logic                clk,
    input  logic                we,
    input  bank_t               wbank,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [SAMPLE_W-1:0] wdata,
    output logic [SAMPLE_W-1:0] rd_prev1,
    output logic [SAMPLE_W-1:0] rd_prev2
);

    logic [SAMPLE_W-1:0] rd_all [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [SAMPLE_W-1:0] mem [LINE_LEN];

        always_ff @(posedge clk) begin
            if (we && (wbank == bank_t'(b))) begin
                mem[addr] <= wdata;
            end
        end

        assign rd_all[b] = mem[addr];
    end

    function automatic logic [SAMPLE_W-1:0] pick(input bank_t b,
                                                 input logic [SAMPLE_W-1:0] r0,
                                                 input logic [SAMPLE_W-1:0] r1,
                                                 input logic [SAMPLE_W-1:0] r2);
        case (b)
            2'd0:    return r0;
            2'd1:    return r1;
            default: return r2;
        endcase
    endfunction

    always_comb begin
        rd_prev1 = pick(bank_dec(wbank), rd_all[0], rd_all[1], rd_all[2]);
        rd_prev2 = pick(bank_dec(bank_dec(wbank)), rd_all[0], rd_all[1], rd_all[2]);
    end

    // R9: writes only ever target one of the three buffers
    always_comb begin
        if (we) begin
            assert_bank_legal_R9: assert (wbank != 2'd3);
        end
    end

endmodule

// File: rtl/vert_avg.sv
`timescale 1ns/1ps
module vert_avg #(
    parameter int SAMPLE_W = 8
) (
    input  logic [SAMPLE_W-1:0] a,
    input  logic [SAMPLE_W-1:0] b,
    output logic [SAMPLE_W-1:0] y
);

    logic [SAMPLE_W:0] sum;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b} + {{SAMPLE_W{1'b0}}, 1'b1};
        y   = sum[SAMPLE_W:1];
    end

    // R6: the mean lies between its inputs, so no wrap occurred
    always_comb begin
        if (!$isunknown({a, b})) begin
            assert_avg_bounds_R6: assert (((y >= a) || (y >= b)) && ((y <= a) || (y <= b)));
        end
    end

endmodule

// File: rtl/chroma_line_interp.sv
`timescale 1ns/1ps
module chroma_line_interp
    import chroma_interp_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int LINE_LEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sol,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_u,
    output logic [SAMPLE_W-1:0] out_v
);

    localparam int ADDR_W = $clog2(LINE_LEN);

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] u;
        logic [SAMPLE_W-1:0] v;
    } out_t;

    out_t out_d, out_q;

    bank_t               wr_bank;
    logic [ADDR_W-1:0]   addr;
    logic                in_range;
    logic                line_odd;
    logic                fill_done;
    logic [SAMPLE_W-1:0] prev1;
    logic [SAMPLE_W-1:0] prev2;
    logic [SAMPLE_W-1:0] mean;

    line_tracker #(.LINE_LEN(LINE_LEN)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .wr_bank  (wr_bank),
        .addr     (addr),
        .in_range (in_range),
        .line_odd (line_odd),
        .fill_done(fill_done)
    );

    line_store #(.SAMPLE_W(SAMPLE_W), .LINE_LEN(LINE_LEN)) u_store (
        .clk     (clk),
        .we      (in_range),
        .wbank   (wr_bank),
        .addr    (addr),
        .wdata   (in_data),
        .rd_prev1(prev1),
        .rd_prev2(prev2)
    );

    vert_avg #(.SAMPLE_W(SAMPLE_W)) u_avg (
        .a(prev2),
        .b(in_data),
        .y(mean)
    );

    // Incoming line odd -> line being emitted is even, and the reverse.
    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (in_range && fill_done) begin
            out_d.valid = 1'b1;
            if (line_odd) begin
                out_d.u = prev1;
                out_d.v = mean;
            end else begin
                out_d.u = mean;
                out_d.v = prev1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_u     = out_q.u;
    assign out_v     = out_q.v;

    // R8: no output without an accepted sample one cycle earlier
    assert_valid_needs_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.valid |-> $past(in_valid));

    // R8: outputs hold while nothing is emitted
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_d.valid |=> ($stable(out_q.u) && $stable(out_q.v)));

endmodule

// File: tb/sim_chroma_line_interp.sv
`timescale 1ns/1ps
module sim_chroma_line_interp;

    localparam int W   = 8;
    localparam int LEN = 8;
    localparam int NL  = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_sol = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic [W-1:0] out_u;
    logic [W-1:0] out_v;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] lm [NL][LEN];

    always #10 clk = ~clk;

    chroma_line_interp #(.SAMPLE_W(W), .LINE_LEN(LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_data(in_data), .out_valid(out_valid), .out_u(out_u), .out_v(out_v)
    );

    function automatic logic [W-1:0] mean2(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b} + 1;
        return s[W:1];
    endfunction

    // Called at a negedge; applies inputs, then checks at the following negedge.
    task automatic step(input logic v, input logic s, input logic [W-1:0] d,
                        input bit ev, input logic [W-1:0] eu, input logic [W-1:0] evv,
                        input string tag);
        in_valid = v;
        in_sol   = s;
        in_data  = d;
        @(negedge clk);
        checks++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL %s: out_valid=%0b expected %0b", tag, out_valid, ev);
        end else if (ev && (out_u !== eu || out_v !== evv)) begin
            errors++;
            $display("FAIL %s: u=%0d v=%0d expected u=%0d v=%0d", tag, out_u, out_v, eu, evv);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, W'($urandom), 1'b0, '0, '0, "R8 idle");
    endtask

    task automatic send_line(input int m, input int extra);
        for (int k = 0; k < LEN; k++) begin
            logic [W-1:0] eu, evv;
            bit           ev;
            string        tag;
            idle($urandom_range(0, 2));
            ev = (m >= 2);
            eu = '0;
            evv = '0;
            tag = "R8 fill";
            if (ev) begin
                int n = m - 1;
                if (n % 2 == 0) begin
                    eu  = lm[n][k];
                    evv = mean2(lm[n-1][k], lm[m][k]);
                    tag = "R2/R3/R7";
                end else begin
                    evv = lm[n][k];
                    eu  = mean2(lm[n-1][k], lm[m][k]);
                    tag = "R4/R5/R7";
                end
                if (n == 4 || n == 7 || n == 10) tag = {tag, " R6"};
            end
            step(1'b1, (k == 0), lm[m][k], ev, eu, evv, tag);
        end
        for (int e = 0; e < extra; e++) step(1'b1, 1'b0, W'($urandom), 1'b0, '0, '0, "R9");
    endtask

    task automatic check_reset_state();
        checks++;
        if (out_valid !== 1'b0 || out_u !== '0 || out_v !== '0) begin
            errors++;
            $display("FAIL R1: valid=%0b u=%0d v=%0d expected 0 0 0", out_valid, out_u, out_v);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int l = 0; l < NL; l++)
            for (int k = 0; k < LEN; k++) lm[l][k] = W'($urandom);
        // R6 rounding corners
        for (int k = 0; k < LEN; k++) begin
            lm[3][k]  = 8'd255; lm[5][k]  = 8'd254;
            lm[6][k]  = 8'd0;   lm[8][k]  = 8'd1;
            lm[9][k]  = 8'd255; lm[11][k] = 8'd255;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // R10: samples before the first line start are ignored
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, W'($urandom), 1'b0, '0, '0, "R10");

        for (int m = 0; m < NL; m++) send_line(m, (m == 5 || m == 8) ? 3 : 0);
        idle(3);

        // Second reset: state and parity restart (R1, R11)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        for (int m = 0; m < 4; m++) send_line(m, 0);
        idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule